// File: doc/BRIEF.md
# Legacy Chipset Memory Address Router

This block is the address decoder of a PC-style host bridge. It receives each memory request from the processor and decides whether the request goes to main DRAM or to the PCI bus. For DRAM targets it also produces the DRAM offset. It flags writes that must be discarded because they hit a shadow segment marked read-only. A small configuration file, written one byte at a time, controls the decode:

- the shadow attributes of the legacy BIOS area;
- the control bits of the SMRAM window;
- the top of low memory;
- the size of the DRAM mapped above 4 GB.

The 128 KB window at 0xA0000 normally belongs to the video adapter on PCI. It can be opened to DRAM, either unconditionally or only while the system-management input is active. The area 0xC0000–0xFFFFF is split into twelve 16 KB segments plus one 64 KB top segment. Each segment has its own 2-bit attribute. Between the programmable top of low memory and 4 GB lies a PCI hole. DRAM hidden under that hole reappears above 4 GB. Everything past the end of that high DRAM is PCI space again.

Each result is registered and presented one cycle after its request, together with a valid strobe.

Top module: `legacy_addr_router`

## Requirements
- R1: After reset all configuration is zero. Every request then goes to PCI with a DRAM address of zero and no write drop, including requests to the SMRAM window and the shadow segments.
- R2: A request accepted with reqValid produces rspValid and its result exactly one cycle later, and rspValid is low after a cycle with no request. A config write applies to requests issued on a later cycle; a request issued in the same cycle as the write still sees the old setting.
- R3: The config index map is as follows. Any write to an index from 12 to 15, or to a bit that no field uses, changes no decode.

  | Index | Bits | Field |
  |---|---|---|
  | 0 | [5:4] | attribute of the 64 KB segment at 0xF0000 |
  | k = 1..6 | [1:0] | attribute of 16 KB segment 2(k−1) |
  | k = 1..6 | [5:4] | attribute of 16 KB segment 2(k−1)+1 |
  | 7 | bit 6 | SMRAM open |
  | 7 | bit 3 | SMRAM enabled while system management is active |
  | 8 / 9 | low / high byte | top of low memory, in 64 KB units |
  | 10 / 11 | low / high byte | above-4 GB DRAM size, in 64 KB units |

  Segment i covers 0xC0000 + i·0x4000 up to the next segment.
- R4: The shadow attribute codes decode as follows, and a DRAM target uses the request address unchanged as the DRAM address.

  | Code | Target |
  |---|---|
  | 3 | DRAM, read and write |
  | 1 | DRAM, read-only |
  | 0 | PCI |
  | 2 | PCI |
- R5: A write to a read-only segment returns DRAM as target with rspWriteDrop high. A read from that segment returns DRAM without the drop flag, and no read ever sets it.
- R6: 0xA0000–0xBFFFF goes to DRAM (address unchanged) when SMRAM bit 6 is set, or when smmActive is high and SMRAM bit 3 is set; otherwise it goes to PCI.
- R7: Any other address below the top of low memory goes to DRAM with the address unchanged.
- R8: Addresses from the top of low memory up to 4 GB go to PCI.
- R9: Addresses from 4 GB up to 4 GB plus the high size go to DRAM with offset (address − 4 GB) + top of low memory.
- R10: Addresses at or beyond 4 GB plus the high size go to PCI, up to the highest address.
- R11: A PCI result always carries DRAM address zero and no write drop.
- R12: The SMRAM window and the shadow segments take priority over low DRAM, even when the top of low memory lies above 1 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Config byte write strobe |
| cfgIdx | input | 4 | Config byte index |
| cfgData | input | 8 | Config byte value |
| smmActive | input | 1 | System-management mode active, sampled with the request |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W (36) | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspToDram | output | 1 | 1 = DRAM target, 0 = PCI |
| rspDramAddr | output | ADDR_W (36) | Translated DRAM address, zero for PCI |
| rspWriteDrop | output | 1 | Write must be discarded |

## Verification
The legacy area is swept in 8 KB steps with reads and writes under each uniform attribute code. This separates the four codes and shows where read-only drops apply. A mixed per-byte pattern follows, which exposes any error in the segment-to-byte or nibble mapping. The SMRAM window is tried under all four combinations of its two control bits, with and without system management, so open mode can be told apart from management-qualified mode. Three memory layouts are then probed at each range boundary, one address either side: a large top of low memory, a top above 1 MB, and a top of zero. These probes pin down range edges, the high relocation offset and the legacy priority, and further steps cover ignored indices and same-cycle config writes.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int IDX_W      = 4;
  localparam int NUM_SEG    = 12;
  localparam int SHADOW_B   = NUM_SEG / 2;
  localparam int CFG_FSEG   = 0;
  localparam int CFG_SMRAM  = SHADOW_B + 1;
  localparam int CFG_TOLM_L = SHADOW_B + 2;
  localparam int CFG_TOLM_H = SHADOW_B + 3;
  localparam int CFG_HIGH_L = SHADOW_B + 4;
  localparam int CFG_HIGH_H = SHADOW_B + 5;
  localparam int GRAN_SHIFT = 16;

  typedef struct packed {
    logic hit;
    logic toDram;
    logic readOnly;
  } legacy_route_t;
endpackage

// File: rtl/lmr_cfg_ctrl.sv
module lmr_cfg_ctrl
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [7:0]          cfgData,
  input  logic                smmActive,
  input  logic [ADDR_W-1:0]   reqAddr,
  output legacy_route_t       route,
  output logic [ADDR_W-1:0]   tolmBase,
  output logic [ADDR_W-1:0]   highSize
);
  localparam int PAD_W = ADDR_W - 16 - GRAN_SHIFT;

  logic [1:0]  attrReg [0:NUM_SEG];
  logic        smramOpen;
  logic        smramSmmEn;
  logic [15:0] tolmReg;
  logic [15:0] highReg;
  logic [3:0]  segIdx;
  logic        lowMeg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= NUM_SEG; s++) attrReg[s] <= 2'b00;
      smramOpen  <= 1'b0;
      smramSmmEn <= 1'b0;
      tolmReg    <= '0;
      highReg    <= '0;
    end else if (cfgWe) begin
      if (cfgIdx == IDX_W'(CFG_FSEG)) attrReg[NUM_SEG] <= cfgData[5:4];
      for (int b = 1; b <= SHADOW_B; b++) begin
        if (cfgIdx == IDX_W'(b)) begin
          attrReg[2*b-2] <= cfgData[1:0];
          attrReg[2*b-1] <= cfgData[5:4];
        end
      end
      if (cfgIdx == IDX_W'(CFG_SMRAM)) begin
        smramOpen  <= cfgData[6];
        smramSmmEn <= cfgData[3];
      end
      if (cfgIdx == IDX_W'(CFG_TOLM_L)) tolmReg[7:0]  <= cfgData;
      if (cfgIdx == IDX_W'(CFG_TOLM_H)) tolmReg[15:8] <= cfgData;
      if (cfgIdx == IDX_W'(CFG_HIGH_L)) highReg[7:0]  <= cfgData;
      if (cfgIdx == IDX_W'(CFG_HIGH_H)) highReg[15:8] <= cfgData;
    end
  end

  assign tolmBase = {{PAD_W{1'b0}}, tolmReg, {GRAN_SHIFT{1'b0}}};
  assign highSize = {{PAD_W{1'b0}}, highReg, {GRAN_SHIFT{1'b0}}};

  // Legacy window decode: SMRAM window first, then shadow segments.
  always_comb begin
    route  = '0;
    segIdx = 4'd0;
    lowMeg = (reqAddr[ADDR_W-1:20] == '0);
    if (lowMeg && reqAddr[19:17] == 3'b101) begin
      route.hit    = 1'b1;
      route.toDram = smramOpen | (smmActive & smramSmmEn);
    end else if (lowMeg && reqAddr[19:18] == 2'b11) begin
      segIdx = (reqAddr[19:16] == 4'hF) ? 4'(NUM_SEG) : reqAddr[17:14];
      route.hit      = 1'b1;
      route.toDram   = attrReg[segIdx][0];
      route.readOnly = (attrReg[segIdx] == 2'b01);
    end
  end

  assert_ro_is_dram_R5: assert property (@(posedge clk) disable iff (rst)
    route.readOnly |-> (route.hit && route.toDram));

  assert_tolm_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && cfgIdx == IDX_W'(CFG_TOLM_H)) |=> (tolmBase[31:24] == $past(cfgData)));
endmodule

// File: rtl/lmr_decode_dp.sv
module lmr_decode_dp
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  legacy_route_t     route,
  input  logic [ADDR_W-1:0] tolmBase,
  input  logic [ADDR_W-1:0] highSize,
  output logic              rspValid,
  output logic              rspToDram,
  output logic [ADDR_W-1:0] rspDramAddr,
  output logic              rspWriteDrop
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  logic [ADDR_W-1:0] highEnd;
  logic [ADDR_W-1:0] nxtAddr;
  logic              nxtDram;
  logic              nxtDrop;

  assign highEnd = FOUR_G + highSize;

  always_comb begin
    nxtDram = 1'b0;
    nxtDrop = 1'b0;
    nxtAddr = '0;
    if (route.hit) begin
      nxtDram = route.toDram;
      nxtDrop = route.toDram & route.readOnly & reqWrite;
      nxtAddr = route.toDram ? reqAddr : '0;
    end else if (reqAddr < tolmBase) begin
      nxtDram = 1'b1;
      nxtAddr = reqAddr;
    end else if (reqAddr < FOUR_G) begin
      nxtDram = 1'b0;
    end else if (reqAddr < highEnd) begin
      nxtDram = 1'b1;
      nxtAddr = reqAddr - FOUR_G + tolmBase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid     <= 1'b0;
      rspToDram    <= 1'b0;
      rspDramAddr  <= '0;
      rspWriteDrop <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspToDram    <= nxtDram;
        rspDramAddr  <= nxtAddr;
        rspWriteDrop <= nxtDrop;
      end
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  assert_pci_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspToDram) |-> (rspDramAddr == '0 && !rspWriteDrop));

  assert_read_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite) |=> !rspWriteDrop);
endmodule

// File: rtl/legacy_addr_router.sv
module legacy_addr_router
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [3:0]        cfgIdx,
  input  logic [7:0]        cfgData,
  input  logic              smmActive,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspToDram,
  output logic [ADDR_W-1:0] rspDramAddr,
  output logic              rspWriteDrop
);
  legacy_route_t     route;
  logic [ADDR_W-1:0] tolmBase;
  logic [ADDR_W-1:0] highSize;

  lmr_cfg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .smmActive(smmActive), .reqAddr(reqAddr), .route(route),
    .tolmBase(tolmBase), .highSize(highSize)
  );

  lmr_decode_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .route(route), .tolmBase(tolmBase),
    .highSize(highSize), .rspValid(rspValid), .rspToDram(rspToDram),
    .rspDramAddr(rspDramAddr), .rspWriteDrop(rspWriteDrop)
  );
endmodule

// File: tb/sim_legacy_addr_router.sv
module sim_legacy_addr_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfgWe;
  logic [3:0]  cfgIdx;
  logic [7:0]  cfgData;
  logic        smmActive;
  logic        reqValid;
  logic [35:0] reqAddr;
  logic        reqWrite;
  logic        rspValid;
  logic        rspToDram;
  logic [35:0] rspDramAddr;
  logic        rspWriteDrop;

  int errors = 0;
  int checks = 0;
  logic [7:0] m [0:11];

  always #5 clk = ~clk;

  legacy_addr_router u0 (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .smmActive(smmActive), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .rspValid(rspValid), .rspToDram(rspToDram),
    .rspDramAddr(rspDramAddr), .rspWriteDrop(rspWriteDrop)
  );

  function automatic void model(input longint a, input bit wr, input bit smm,
                                output bit td, output longint da, output bit dr);
    longint tolm, hi, fourG;
    int seg, attr;
    logic [7:0] b;
    fourG = 64'h1_0000_0000;
    tolm = longint'({m[9], m[8]}) << 16;
    hi   = longint'({m[11], m[10]}) << 16;
    td = 0; da = 0; dr = 0;
    if (a >= 'hA0000 && a < 'hC0000) begin
      td = m[7][6] | (smm & m[7][3]);
      da = td ? a : 0;
    end else if (a >= 'hC0000 && a < 'h100000) begin
      if (a >= 'hF0000) attr = int'(m[0][5:4]);
      else begin
        seg = int'((a - 'hC0000) / 'h4000);
        b = m[1 + seg / 2];
        attr = (seg % 2 == 1) ? int'(b[5:4]) : int'(b[1:0]);
      end
      td = (attr == 1 || attr == 3);
      dr = wr && attr == 1;
      da = td ? a : 0;
    end else if (a < tolm) begin
      td = 1; da = a;
    end else if (a < fourG) begin
      td = 0;
    end else if (a < fourG + hi) begin
      td = 1; da = a - fourG + tolm;
    end
  endfunction

  task automatic cfg(input int idx, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 4'(idx); cfgData = 8'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    if (idx < 12) m[idx] = 8'(data);
  endtask

  task automatic compare(input string tag, input longint a, input bit td,
                         input longint da, input bit dr);
    checks++;
    if (!(rspValid === 1'b1 && rspToDram === td && rspDramAddr === 36'(da) &&
          rspWriteDrop === dr)) begin
      errors++;
      $display("FAIL %s addr=%h actual v=%b dram=%b a=%h drop=%b expected v=1 dram=%b a=%h drop=%b",
               tag, a, rspValid, rspToDram, rspDramAddr, rspWriteDrop, td, 36'(da), dr);
    end
  endtask

  task automatic req(input string tag, input longint a, input bit wr, input bit smm);
    bit td, dr;
    longint da;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 36'(a); reqWrite = wr; smmActive = smm;
    model(a, wr, smm, td, da, dr);
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, a, td, da, dr);
  endtask

  task automatic boundaries(input string tag);
    longint tolm, hi, fourG;
    longint pts [9];
    fourG = 64'h1_0000_0000;
    tolm = longint'({m[9], m[8]}) << 16;
    hi   = longint'({m[11], m[10]}) << 16;
    pts = '{0, 'h9FFFF, tolm - 1, tolm, fourG - 1, fourG, fourG + hi - 1,
            fourG + hi, 64'hF_FFFF_FFFF};
    foreach (pts[k]) begin
      if (pts[k] >= 0) begin
        req(tag, pts[k], 1'b0, 1'b0);
        req(tag, pts[k], 1'b1, 1'b0);
      end
    end
  endtask

  task automatic legacySweep(input string tag, input int step);
    for (longint a = 'hA0000; a < 'h100000; a += step) begin
      req(tag, a, 1'b0, 1'b0);
      req(tag, a, 1'b1, 1'b0);
      req(tag, a + step - 1, 1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (m[i]) m[i] = 8'h00;
    rst = 1'b1; cfgWe = 1'b0; cfgIdx = '0; cfgData = '0; smmActive = 1'b0;
    reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspToDram !== 1'b0 || rspDramAddr !== '0 || rspWriteDrop !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual v=%b d=%b a=%h w=%b expected all zero",
               rspValid, rspToDram, rspDramAddr, rspWriteDrop);
    end
    // R1: default routing everywhere
    legacySweep("R1", 'h8000);
    req("R1", 'hA0000, 1'b0, 1'b1);
    boundaries("R1");

    // R4 / R5: uniform attribute codes
    for (int at = 0; at < 4; at++) begin
      for (int b = 0; b <= 6; b++) cfg(b, (at << 4) | at);
      legacySweep(at == 1 ? "R5" : "R4", 'h2000);
    end

    // R3: mixed per-byte pattern, including unused bits
    for (int b = 0; b <= 6; b++) cfg(b, (b * 37 + 11) & 8'hFF);
    legacySweep("R3", 'h4000);

    // R6: SMRAM combinations
    for (int s = 0; s < 4; s++) begin
      cfg(7, ((s >> 1) << 6) | ((s & 1) << 3) | 8'h84);
      for (int smm = 0; smm < 2; smm++) begin
        req("R6", 'hA0000, 1'b0, 1'(smm));
        req("R6", 'hBFFFF, 1'b1, 1'(smm));
      end
    end

    // R7-R10: range boundaries under three layouts
    cfg(8, 8'h00); cfg(9, 8'hE0); cfg(10, 8'h00); cfg(11, 8'h01);
    boundaries("R9");
    req("R8", 64'hE000_1234, 1'b1, 1'b0);
    req("R7", 64'h0123_4567, 1'b0, 1'b0);
    // R12: top of low memory above 1 MB, legacy still wins
    for (int b = 0; b <= 6; b++) cfg(b, 8'h00);
    cfg(7, 8'h00);
    cfg(8, 8'h20); cfg(9, 8'h00); cfg(10, 8'h10); cfg(11, 8'h00);
    boundaries("R10");
    legacySweep("R12", 'h10000);
    cfg(8, 8'h00); cfg(10, 8'h01);
    boundaries("R11");
    req("R9", 64'h1_0000_8000, 1'b0, 1'b0);

    // R3: ignored indices change nothing
    for (int ix = 12; ix < 16; ix++) cfg(ix, 8'hFF);
    legacySweep("R3", 'h10000);
    boundaries("R3");

    // R2: config write in the same cycle as a request
    begin
      bit td, dr;
      longint da;
      model('hC0000, 1'b0, 1'b0, td, da, dr);
      @(negedge clk);
      cfgWe = 1'b1; cfgIdx = 4'd1; cfgData = 8'h03;
      reqValid = 1'b1; reqAddr = 36'hC0000; reqWrite = 1'b0; smmActive = 1'b0;
      @(negedge clk);
      cfgWe = 1'b0; reqValid = 1'b0;
      compare("R2", 'hC0000, td, da, dr);
      m[1] = 8'h03;
      @(negedge clk);
      checks++;
      if (rspValid !== 1'b0) begin
        errors++;
        $display("FAIL R2 idle valid actual=%b expected=0", rspValid);
      end
      req("R2", 'hC0000, 1'b0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule